// File: doc/BRIEF.md
# Programmable Serial Bit Clock Generator

This block is the clock source for a serial channel that runs as bit clock master. It divides the system clock by a value set on a divider input and drives the serial bit clock from the result. It also gives a one-cycle strobe, aligned to the system clock, that marks each rising edge of the serial clock. Downstream framing and shift logic use this strobe as a clock enable, so they never need to run on the derived clock.

The division ratio comes from an unsigned divider field. In normal mode the period is (divider + 1) system clock cycles. In compatibility mode the period is twice that, which halves the whole rate range. A divider of zero in normal mode asks for the full system clock rate. A toggling register cannot produce that rate, so in that case the output is the system clock passed through a glitch-free gate.

While the channel sleeps, or while the channel is set to take its bit clock from outside, the output is held low and the strobe stays quiet. When sleep is released, the first period starts on the first rising system clock edge. A new divider or mode value is picked up only at a period boundary, so a change never produces a runt pulse.

Top module: `sclkgen_top`

## Requirements
- R1: While reset is asserted (rst_ni low), sclk_o and sclk_rise_o are both 0.
- R2: In normal mode (compat_i = 0) with divider d >= 1, sclk_rise_o is high for one system clock cycle every d + 1 cycles.
- R3: In compatibility mode (compat_i = 1), the period is 2 x (d + 1) system clock cycles. sclk_o is high for the first d + 1 cycles of each period and low for the rest.
- R4: In normal mode with d >= 1, the period P = d + 1 starts with floor(P/2) cycles high, and the remaining cycles are low. An odd P therefore has the longer low phase.
- R5: In normal mode with d = 0, sclk_o equals the system clock (high while clk_i is high, low while clk_i is low), and sclk_rise_o stays high in every cycle.
- R6: When sleep_i is 1 at a rising clock edge, sclk_o is 0 and sclk_rise_o is 0 for the following cycle.
- R7: If sleep_i is 0 at the first rising edge after a sleeping cycle, a new period starts at that edge: sclk_o goes high and sclk_rise_o is 1 in that cycle.
- R8: A change of div_i or compat_i while running leaves the current period unchanged. The new value sets the period that starts at the next boundary.
- R9: When slave_sel_i is 1 at a rising edge, sclk_o and sclk_rise_o are 0 for the following cycle.
- R10: In divided modes, sclk_rise_o is 1 exactly in the cycles in which sclk_o has just gone from low to high, or in which a period has just begun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Channel sleep; 1 holds the output low |
| slave_sel_i | input | 1 | 1 selects an external bit clock, which disables this output |
| div_i | input | DIV_W | Unsigned divider value d |
| compat_i | input | 1 | 1 doubles the division ratio |
| sclk_o | output | 1 | Serial bit clock |
| sclk_rise_o | output | 1 | One-cycle strobe marking each serial clock rising edge |

## Verification
The assertions assume that sleep_i, slave_sel_i, div_i and compat_i are synchronous to clk_i and stay stable around its rising edge. They also assume these inputs are settled before clk_i falls, because the bypass gate latches its enable while the clock is low. The stimulus meets this by changing every input one nanosecond after a rising edge, well inside the high phase. The divider is changed in the middle of running periods, and sleep and slave select are applied during both high and low phases of the output. This tests the boundary rule and the forced-low behaviour without ever violating the timing assumption.

// File: rtl/sclkgen_pkg.sv
package sclkgen_pkg;

   // Operating state of the period sequencer
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,   // output held low
      ST_BYP  = 2'd1,   // full-rate gated system clock
      ST_DIV  = 2'd2    // counter-generated divided clock
   } sclk_state_e;

   // Largest divider width the block accepts
   localparam int unsigned MAX_DIV_W = 10;

endpackage

// File: rtl/sclkgen_cfg.sv
module sclkgen_cfg #(
   parameter int unsigned DIV_W     = 5,
   parameter bit          COMPAT_EN = 1'b1,
   localparam int unsigned PER_W    = DIV_W + 2
) (
   input  logic [DIV_W-1:0] div_i,
   input  logic             compat_i,
   output logic [PER_W-1:0] per_o,
   output logic [PER_W-1:0] hi_o
);

   logic [PER_W-1:0] per_norm;
   logic [PER_W-1:0] hi_norm;

   assign per_norm = PER_W'(div_i) + PER_W'(1);
   assign hi_norm  = per_norm >> 1;

   generate
      if (COMPAT_EN) begin : g_compat
         logic [PER_W-1:0] per_cmp;
         assign per_cmp = per_norm << 1;
         assign per_o   = compat_i ? per_cmp  : per_norm;
         assign hi_o    = compat_i ? per_norm : hi_norm;
      end else begin : g_norm_only
         logic unused_compat;
         assign unused_compat = compat_i;
         assign per_o = per_norm;
         assign hi_o  = hi_norm;
      end
   endgenerate

endmodule

// File: rtl/sclkgen_seq.sv
module sclkgen_seq
   import sclkgen_pkg::*;
#(
   parameter int unsigned PER_W = 7
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             active_i,
   input  logic [PER_W-1:0] per_i,
   input  logic [PER_W-1:0] hi_i,
   output logic             div_sclk_o,
   output logic             strobe_o,
   output logic             byp_next_o
);

   sclk_state_e      state_q, state_n;
   logic [PER_W-1:0] cnt_q, cnt_n;
   logic [PER_W-1:0] per_q, per_n;
   logic [PER_W-1:0] hi_q, hi_n;
   logic             div_sclk_q, div_sclk_n;
   logic             strobe_q;
   logic             start;

   always_comb begin
      start   = active_i && ((state_q == ST_IDLE) || (cnt_q == per_q - PER_W'(1)));
      per_n   = start ? per_i : per_q;
      hi_n    = start ? hi_i  : hi_q;
      if (!active_i || start) cnt_n = '0;
      else                    cnt_n = cnt_q + PER_W'(1);
      if (!active_i)                  state_n = ST_IDLE;
      else if (per_n == PER_W'(1))    state_n = ST_BYP;
      else                            state_n = ST_DIV;
      div_sclk_n = (state_n == ST_DIV) && (cnt_n < hi_n);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q    <= ST_IDLE;
         cnt_q      <= '0;
         per_q      <= PER_W'(1);
         hi_q       <= '0;
         div_sclk_q <= 1'b0;
         strobe_q   <= 1'b0;
      end else begin
         state_q    <= state_n;
         cnt_q      <= cnt_n;
         per_q      <= per_n;
         hi_q       <= hi_n;
         div_sclk_q <= div_sclk_n;
         strobe_q   <= start;
      end
   end

   assign div_sclk_o = div_sclk_q;
   assign strobe_o   = strobe_q;
   assign byp_next_o = (state_n == ST_BYP);

   // R6/R9: an inactive channel produces nothing in the next cycle
   a_r6_inactive_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !active_i |=> (!div_sclk_q && !strobe_q));

   // R2: in divided mode two strobes are never adjacent
   a_r2_strobe_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (strobe_q && state_q == ST_DIV) |=> !strobe_q);

   // R7: waking from idle starts a period at once
   a_r7_wake_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_IDLE && active_i) |=> strobe_q);

   // R10: every rising edge of the divided clock carries the strobe
   a_r10_rise_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(div_sclk_q) |-> strobe_q);

   // R8: the period length holds inside a running period
   a_r8_period_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != ST_IDLE && cnt_q != '0) |-> $stable(per_q));

endmodule

// File: rtl/sclkgen_gate.sv
module sclkgen_gate (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic byp_next_i,
   input  logic div_sclk_i,
   output logic sclk_o
);

   logic en_l;

   // Enable is captured while the clock is low, so the AND gate cannot glitch
   always_latch begin
      if (!rst_ni)     en_l = 1'b0;
      else if (!clk_i) en_l = byp_next_i;
   end

   assign sclk_o = (clk_i & en_l) | div_sclk_i;

   // R5: bypass gating and the divided path are never on together
   a_r5_bypass_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_l |-> !div_sclk_i);

endmodule

// File: rtl/sclkgen_top.sv
module sclkgen_top
   import sclkgen_pkg::*;
#(
   parameter int unsigned DIV_W     = 5,
   parameter bit          COMPAT_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sleep_i,
   input  logic             slave_sel_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             compat_i,
   output logic             sclk_o,
   output logic             sclk_rise_o
);

   localparam int unsigned PER_W = DIV_W + 2;

   generate
      if (DIV_W < 1 || DIV_W > MAX_DIV_W) begin : g_bad_width
         $error("sclkgen_top: DIV_W out of range");
      end
   endgenerate

   logic             active;
   logic [PER_W-1:0] per_cfg;
   logic [PER_W-1:0] hi_cfg;
   logic             div_sclk;
   logic             strobe;
   logic             byp_next;

   assign active = !sleep_i && !slave_sel_i;

   sclkgen_cfg #(.DIV_W(DIV_W), .COMPAT_EN(COMPAT_EN)) u_cfg (
      .div_i    (div_i),
      .compat_i (compat_i),
      .per_o    (per_cfg),
      .hi_o     (hi_cfg)
   );

   sclkgen_seq #(.PER_W(PER_W)) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .active_i   (active),
      .per_i      (per_cfg),
      .hi_i       (hi_cfg),
      .div_sclk_o (div_sclk),
      .strobe_o   (strobe),
      .byp_next_o (byp_next)
   );

   sclkgen_gate u_gate (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .byp_next_i (byp_next),
      .div_sclk_i (div_sclk),
      .sclk_o     (sclk_o)
   );

   assign sclk_rise_o = strobe;

   // R9: slave selection silences the strobe in the next cycle
   a_r9_slave_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slave_sel_i |=> !sclk_rise_o);

endmodule

// File: tb/sclkgen_top_bench.sv
module sclkgen_top_bench;

   localparam int DW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep = 1'b1;
   logic          slave = 1'b0;
   logic          compat = 1'b0;
   logic [DW-1:0] div = '0;
   logic          sclk;
   logic          rise;

   sclkgen_top #(.DIV_W(DW)) u_sclkgen_top (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .sleep_i     (sleep),
      .slave_sel_i (slave),
      .div_i       (div),
      .compat_i    (compat),
      .sclk_o      (sclk),
      .sclk_rise_o (rise)
   );

   always #4 clk = ~clk;

   typedef struct {
      int    cyc;
      bit    sck;
      bit    stb;
      bit    byp;
      string tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails  = 0;
   int   cyc    = 0;
   bit   m_run  = 1'b0;
   int   m_pos  = 0;
   int   m_per  = 1;
   int   m_hi   = 0;

   always @(posedge clk) cyc = cyc + 1;

   task automatic check(string tag, string what, logic act, bit exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b at cycle %0d", tag, what, act, exp, cyc);
      end
   endtask

   // Reference model: works out the expected outputs from the requirements
   task automatic drive(bit s, bit sl, int d, bit c, int n, string tag);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         @(posedge clk);
         #1;
         sleep  = s;
         slave  = sl;
         div    = d[DW-1:0];
         compat = c;
         e.cyc  = cyc + 1;
         e.tag  = tag;
         if (s || sl) begin
            m_run = 1'b0;
            e.sck = 1'b0;
            e.stb = 1'b0;
            e.byp = 1'b0;
         end else begin
            if (!m_run || m_pos == m_per - 1) begin
               m_per = c ? 2 * (d + 1) : d + 1;
               m_hi  = c ? d + 1 : m_per / 2;
               m_pos = 0;
               m_run = 1'b1;
               e.stb = 1'b1;
            end else begin
               m_pos++;
               e.stb = 1'b0;
            end
            e.byp = (m_per == 1);
            e.sck = e.byp ? 1'b1 : (m_pos < m_hi);
         end
         q.push_back(e);
      end
   endtask

   // Monitor: pops the expected item for the current cycle and compares
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0 && q[0].cyc == cyc) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, "sclk", sclk, e.sck);
            check(e.tag, "strobe", rise, e.stb);
            if (e.byp) begin
               @(negedge clk);
               #2;
               check(e.tag, "sclk low phase", sclk, 1'b0);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      // R1: reset holds both outputs low even with the channel awake
      sleep = 1'b0;
      div   = 5'd2;
      for (int i = 0; i < 3; i++) begin
         @(posedge clk);
         #2;
         check("R1", "sclk", sclk, 1'b0);
         check("R1", "strobe", rise, 1'b0);
      end
      sleep = 1'b1;
      @(posedge clk);
      #1;
      rst_n = 1'b1;

      drive(1, 0, 3, 0, 5, "R6");
      drive(0, 0, 3, 0, 1, "R7");
      drive(0, 0, 3, 0, 14, "R2 R4 R10");
      drive(0, 0, 4, 0, 2, "R8");
      drive(0, 0, 4, 0, 18, "R4 R8");
      drive(0, 0, 0, 0, 10, "R5");
      drive(0, 0, 2, 1, 26, "R3");
      drive(0, 0, 0, 1, 8, "R3");
      drive(0, 0, 5, 0, 3, "R8");
      drive(0, 0, 5, 1, 16, "R8 R3");
      drive(0, 1, 5, 0, 6, "R9");
      drive(0, 0, 6, 0, 16, "R7 R4");
      drive(0, 0, 6, 0, 2, "R6");
      drive(1, 0, 6, 0, 4, "R6");
      drive(0, 0, 31, 0, 70, "R2 R10");
      drive(0, 0, 31, 1, 130, "R3");
      drive(0, 0, 0, 0, 3, "R5");
      drive(0, 1, 0, 0, 3, "R9");
      drive(0, 0, 1, 0, 8, "R2 R4");

      repeat (4) @(posedge clk);
      #3;
      checks++;
      if (q.size() != 0) begin
         fails++;
         $display("FAIL queue drain actual=%0d expected=0", q.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule